// File: doc/BRIEF.md
# Serial Receive Buffer with Status Flags

This block sits between a serial deserializer and a register bus. Each character the deserializer delivers arrives with two error tags, one for framing and one for parity. The block stores the character and its tags in a 16-entry first-in-first-out buffer. The character at the head of the buffer is always visible on the read-data output, and a pop strobe advances the buffer to the next character.

A 16-bit status word reports five flags and the fill count. The framing-error and parity-error bits describe the character currently at the head. A threshold flag rises once the fill count reaches a software-chosen trigger level. An idle flag rises when a few characters are waiting, but fewer than the trigger level, and no new character has arrived for fifteen character times. A sticky overrun flag records a character that was lost because the buffer was full.

The threshold, idle and overrun flags clear only through a two-step handshake. Software first reads the status word while the flag is 1, then writes 0 to that bit. A standby input forces every flag to zero and keeps the stored characters.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: Characters leave in arrival order. `rd_data_o` shows the head character, and `rd_pop_i` removes it. A pop on an empty buffer changes nothing, and the data shown then is undefined.
- R2: `status_o[12:8]` holds the fill count, from 0 to 16. `status_o[15:13]` and `status_o[7:5]` read 0.
- R3: `status_o[3]` is the framing-error tag of the head character, and reads 0 when the buffer is empty.
- R4: `status_o[2]` is the parity-error tag of the head character, and reads 0 when the buffer is empty.
- R5: `trig_sel_i` selects the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. `status_o[1]` becomes 1 on the cycle after the fill count is at or above the level.
- R6: `status_o[1]` clears only when three conditions hold at one status write:
  - an earlier status read saw the bit as 1;
  - the write carries 0 in bit 1;
  - the fill count is below the level.
  Any status write cancels an earlier read, whatever data it carries.
- R7: `status_o[0]` becomes 1 when three conditions hold together:
  - 15 × `FRAME_BITS` pulses of `bit_tick_i` have passed with no character arrival and no pop;
  - the buffer is not empty;
  - the fill count is below the level.
  It does not become 1 while the buffer is empty or at or above the level.
- R8: `status_o[0]` stays 1 until it is cleared by the same read-then-write-0 handshake as R6, on bit 0. A pop does not clear it.
- R9: A character that arrives while the buffer is full and no pop happens in the same cycle is discarded. It sets the sticky `status_o[4]`, which clears by the read-then-write-0 handshake on bit 4.
- R10: When a character arrives and a pop happens in the same cycle on a full buffer, both take effect. The count stays 16 and `status_o[4]` does not change.
- R11: One cycle after `standby_i` goes high, `status_o[4:0]` reads 0 and stays 0 while `standby_i` stays high. The stored characters and the count are kept.
- R12: After reset the buffer is empty and `status_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| standby_i | input | 1 | Low-power state; forces all flags to zero |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| rx_valid_i | input | 1 | Character from the deserializer is valid this cycle |
| rx_data_i | input | 8 | Received character |
| rx_ferr_i | input | 1 | Framing-error tag of the character |
| rx_perr_i | input | 1 | Parity-error tag of the character |
| trig_sel_i | input | 2 | Trigger-level select |
| rd_pop_i | input | 1 | Remove the head character |
| rd_data_o | output | 8 | Head character |
| stat_rd_i | input | 1 | Status word is being read this cycle |
| stat_wr_i | input | 1 | Status word is being written this cycle |
| stat_wdata_i | input | 16 | Status write data; bits 0, 1 and 4 request clears |
| status_o | output | 16 | Flags in bits 4:0, fill count in bits 12:8 |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an arrival and a pop on a completely full buffer. The bench fills all 16 entries, then raises both strobes together. It judges the result three ways:
- the count stays 16;
- the overrun bit stays 0;
- after 15 further pops, the character that arrived with the pop is at the head.

The second pair is a clearing write and a threshold that still holds. The bench arms the handshake and writes 0 while the count is at or above the level. It judges that the flag stays 1. It then confirms that a later clear needs a fresh read, and that a write of 1 never clears the flag.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

  localparam int CHAR_W     = 8;
  localparam int STAT_W     = 16;
  localparam int ST_IDLE    = 0;
  localparam int ST_THR     = 1;
  localparam int ST_PERR    = 2;
  localparam int ST_FERR    = 3;
  localparam int ST_OVR     = 4;
  localparam int ST_CNT_LSB = 8;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  // Trigger level chosen by the 2-bit select (R5)
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = 4;
      2'd2:    trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import uart_rxf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  rx_char_t         wr_char_i,
  output rx_char_t         head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             drop_o
);

  rx_char_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             full, empty, do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    do_pop  = pop_i && !empty;                  // R1: pop on empty is ignored
    do_push = push_i && (!full || do_pop);      // R10: a same-cycle pop frees a slot
    drop_o  = push_i && !do_push;               // R9: character lost
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    if (do_push) wr_ptr_n = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_n = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    cnt_n = cnt_q;
    if (do_push && !do_pop)      cnt_n = cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  // Storage has no reset; each entry has its own write enable
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (do_push && (wr_ptr_q == PTR_W'(e))) mem[e] <= wr_char_i;
    end
  end

  assign head_o  = mem[rd_ptr_q];
  assign count_o = cnt_q;

endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
  parameter  int LIMIT = 150,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic expire_o
);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (hold_i || restart_i)                  cnt_n = '0;
    else if (tick_i && cnt_q < CW'(LIMIT))    cnt_n = cnt_q + CW'(1);
    // One-cycle pulse when the count reaches the limit (R7)
    expire_o = tick_i && !hold_i && !restart_i && (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/rxf_flag_ctl.sv
module rxf_flag_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic             expire_i,
  input  logic             drop_i,
  input  logic             stat_rd_i,
  input  logic             stat_wr_i,
  input  logic [2:0]       wr_bits_i,    // {overrun, threshold, idle}
  output logic             idle_o,
  output logic             thr_o,
  output logic             ovr_o
);

  localparam int NF    = 3;
  localparam int F_IDL = 0;
  localparam int F_THR = 1;
  localparam int F_OVR = 2;

  logic [NF-1:0] flag_q, flag_n, arm_q, arm_n, set_c, clr_ok_c;
  logic          below;

  always_comb begin
    below           = (count_i < level_i);
    set_c[F_IDL]    = expire_i && (count_i != '0) && below;   // R7
    set_c[F_THR]    = !below;                                  // R5
    set_c[F_OVR]    = drop_i;                                  // R9
    clr_ok_c[F_IDL] = 1'b1;
    clr_ok_c[F_THR] = below;                                   // R6
    clr_ok_c[F_OVR] = 1'b1;
  end

  // Same set/arm/clear structure for every clearable flag (R6, R8, R9)
  for (genvar k = 0; k < NF; k++) begin : g_flag
    assign arm_n[k] = standby_i ? 1'b0 :
                      stat_wr_i ? 1'b0 :
                      (stat_rd_i && flag_q[k]) ? 1'b1 : arm_q[k];
    assign flag_n[k] = standby_i ? 1'b0 :
                       set_c[k]  ? 1'b1 :
                       (stat_wr_i && arm_q[k] && !wr_bits_i[k] && clr_ok_c[k]) ? 1'b0 :
                       flag_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign idle_o = flag_q[F_IDL];
  assign thr_o  = flag_q[F_THR];
  assign ovr_o  = flag_q[F_OVR];

endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
  import uart_rxf_pkg::*;
#(
  parameter  int DEPTH      = 16,
  parameter  int FRAME_BITS = 10,
  parameter  int IDLE_CHARS = 15,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int IDLE_TICKS = IDLE_CHARS * FRAME_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              bit_tick_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_ferr_i,
  input  logic              rx_perr_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              rd_pop_i,
  output logic [CHAR_W-1:0] rd_data_o,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] status_o
);

  // Reset: asserted asynchronously, released through two flops (R12)
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rx_char_t         in_char, head;
  logic [CNT_W-1:0] count, level;
  logic             drop, expire, idle_f, thr_f, ovr_f, standby_q;
  logic             unused_wd;

  assign in_char   = '{ferr: rx_ferr_i, perr: rx_perr_i, data: rx_data_i};
  assign level     = CNT_W'(trig_level(trig_sel_i));
  assign unused_wd = ^{stat_wdata_i[STAT_W-1:ST_OVR+1], stat_wdata_i[ST_FERR:ST_PERR]};

  rxf_store #(.DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (rx_valid_i),
    .pop_i     (rd_pop_i),
    .wr_char_i (in_char),
    .head_o    (head),
    .count_o   (count),
    .drop_o    (drop)
  );

  rxf_idle_timer #(.LIMIT(IDLE_TICKS)) timer_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hold_i    (standby_i),
    .tick_i    (bit_tick_i),
    .restart_i (rx_valid_i || rd_pop_i),
    .expire_o  (expire)
  );

  rxf_flag_ctl #(.CNT_W(CNT_W)) flags_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .standby_i (standby_i),
    .count_i   (count),
    .level_i   (level),
    .expire_i  (expire),
    .drop_i    (drop),
    .stat_rd_i (stat_rd_i),
    .stat_wr_i (stat_wr_i),
    .wr_bits_i ({stat_wdata_i[ST_OVR], stat_wdata_i[ST_THR], stat_wdata_i[ST_IDLE]}),
    .idle_o    (idle_f),
    .thr_o     (thr_f),
    .ovr_o     (ovr_f)
  );

  // Registered standby masks the head-character error tags (R11)
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) standby_q <= 1'b0;
    else             standby_q <= standby_i;
  end

  always_comb begin
    status_o                         = '0;
    status_o[ST_IDLE]                = idle_f;
    status_o[ST_THR]                 = thr_f;
    status_o[ST_PERR]                = head.perr && (count != '0) && !standby_q;   // R4
    status_o[ST_FERR]                = head.ferr && (count != '0) && !standby_q;   // R3
    status_o[ST_OVR]                 = ovr_f;
    status_o[ST_CNT_LSB +: CNT_W]    = count;                                        // R2
  end

  assign rd_data_o = head.data;

endmodule

// File: rtl/uart_rxf_chk.sv
module uart_rxf_chk
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby_i,
  input logic             rx_valid_i,
  input logic             rd_pop_i,
  input logic             stat_wr_i,
  input logic [1:0]       trig_sel_i,
  input logic [4:0]       flags_i,
  input logic [CNT_W-1:0] count_i
);

  logic [CNT_W-1:0] lvl;
  assign lvl = CNT_W'(trig_level(trig_sel_i));

  p_push_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !rd_pop_i && count_i < CNT_W'(DEPTH)) |=> count_i == $past(count_i) + CNT_W'(1));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_i <= CNT_W'(DEPTH));

  p_empty_tags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) |-> (!flags_i[ST_FERR] && !flags_i[ST_PERR]));   // also covers R4

  p_thr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i >= lvl && !standby_i) |=> flags_i[ST_THR]);

  p_thr_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[ST_THR] && !stat_wr_i && !standby_i) |=> flags_i[ST_THR]);

  p_idle_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[ST_IDLE] && !stat_wr_i && !standby_i) |=> flags_i[ST_IDLE]);

  p_drop_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !rd_pop_i && count_i == CNT_W'(DEPTH) && !standby_i) |=> flags_i[ST_OVR]);

  p_full_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rd_pop_i && count_i == CNT_W'(DEPTH) && !standby_i && !stat_wr_i)
      |=> (count_i == CNT_W'(DEPTH) && flags_i[ST_OVR] == $past(flags_i[ST_OVR])));

  p_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> flags_i == 5'd0);

endmodule

bind uart_rx_fifo_status uart_rxf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .standby_i  (standby_i),
  .rx_valid_i (rx_valid_i),
  .rd_pop_i   (rd_pop_i),
  .stat_wr_i  (stat_wr_i),
  .trig_sel_i (trig_sel_i),
  .flags_i    (status_o[4:0]),
  .count_i    (status_o[12:8])
);

// File: tb/uart_rx_fifo_status_tb_top.sv
module uart_rx_fifo_status_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, tick = 1'b0, rxv = 1'b0, ferr = 1'b0, perr = 1'b0;
  logic [7:0]  rxd = '0;
  logic [1:0]  tsel = '0;
  logic        pop = 1'b0, srd = 1'b0, swr = 1'b0;
  logic [15:0] swd = '0;
  logic [7:0]  rdata;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  uart_rx_fifo_status dut_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .bit_tick_i(tick),
    .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ferr_i(ferr), .rx_perr_i(perr),
    .trig_sel_i(tsel), .rd_pop_i(pop), .rd_data_o(rdata),
    .stat_rd_i(srd), .stat_wr_i(swr), .stat_wdata_i(swd), .status_o(status)
  );

  // Trigger-select field, pushes and expected threshold bit
  localparam logic [7:0] VEC [8] = '{
    {2'd0, 5'd0,  1'b0}, {2'd0, 5'd1,  1'b1},
    {2'd1, 5'd3,  1'b0}, {2'd1, 5'd4,  1'b1},
    {2'd2, 5'd7,  1'b0}, {2'd2, 5'd8,  1'b1},
    {2'd3, 5'd13, 1'b0}, {2'd3, 5'd14, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic p);
    @(negedge clk);
    rxv = 1'b1; rxd = d; ferr = f; perr = p;
    @(negedge clk);
    rxv = 1'b0; ferr = 1'b0; perr = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic push_pop(input logic [7:0] d);
    @(negedge clk);
    rxv = 1'b1; rxd = d; pop = 1'b1;
    @(negedge clk);
    rxv = 1'b0; pop = 1'b0;
  endtask

  task automatic sread();
    @(negedge clk);
    srd = 1'b1;
    @(negedge clk);
    srd = 1'b0;
  endtask

  task automatic swrite(input logic [15:0] v);
    @(negedge clk);
    swr = 1'b1; swd = v;
    @(negedge clk);
    swr = 1'b0; swd = '0;
  endtask

  initial begin
    do_reset();
    chk("R12 status after reset", status, 16'h0000);

    // R5: threshold bit against each trigger level
    for (int i = 0; i < 8; i++) begin
      do_reset();
      tsel = VEC[i][7:6];
      for (int j = 0; j < int'(VEC[i][5:1]); j++) push(8'(j), 1'b0, 1'b0);
      idle(1);
      chk("R5 threshold bit", {15'd0, status[1]}, {15'd0, VEC[i][0]});
      chk("R2 fill count", {11'd0, status[12:8]}, {11'd0, VEC[i][5:1]});
    end

    // R1, R3, R4: order and head tags
    do_reset();
    tsel = 2'd3;
    push(8'hA5, 1'b1, 1'b0);
    push(8'h3C, 1'b0, 1'b1);
    push(8'h77, 1'b0, 1'b0);
    chk("R1 head data first", {8'd0, rdata}, 16'h00A5);
    chk("R3 framing tag of head", {14'd0, status[3:2]}, 16'h0002);
    pop1();
    chk("R1 head data second", {8'd0, rdata}, 16'h003C);
    chk("R4 parity tag of head", {14'd0, status[3:2]}, 16'h0001);
    pop1();
    chk("R1 head data third", {8'd0, rdata}, 16'h0077);
    pop1();
    pop1();   // pop on empty buffer
    chk("R1 pop on empty keeps count 0", {11'd0, status[12:8]}, 16'd0);
    chk("R3 tags zero when empty", {14'd0, status[3:2]}, 16'd0);
    chk("R2 reserved bits zero", {10'd0, status[15:13], status[7:5]}, 16'd0);

    // R6: threshold clear handshake
    do_reset();
    tsel = 2'd1;
    for (int j = 0; j < 5; j++) push(8'(j), 1'b0, 1'b0);
    idle(1);
    chk("R6 threshold set", {15'd0, status[1]}, 16'd1);
    swrite(16'h0000);
    chk("R6 write without read keeps flag", {15'd0, status[1]}, 16'd1);
    sread();
    swrite(16'h0000);
    chk("R6 clear blocked at/above level", {15'd0, status[1]}, 16'd1);
    pop1(); pop1();
    idle(1);
    swrite(16'h0000);
    chk("R6 earlier write consumed the read", {15'd0, status[1]}, 16'd1);
    sread();
    swrite(16'h0002);
    chk("R6 writing 1 does not clear", {15'd0, status[1]}, 16'd1);
    sread();
    swrite(16'h0000);
    chk("R6 handshake clears below level", {15'd0, status[1]}, 16'd0);

    // R9: overrun
    do_reset();
    tsel = 2'd3;
    for (int j = 0; j < 16; j++) push(8'(j), 1'b0, 1'b0);
    push(8'hEE, 1'b0, 1'b0);
    chk("R9 count stays 16 on drop", {11'd0, status[12:8]}, 16'd16);
    chk("R9 overrun set", {15'd0, status[4]}, 16'd1);
    for (int j = 0; j < 15; j++) pop1();
    chk("R9 dropped character not stored", {8'd0, rdata}, 16'h000F);
    pop1();
    chk("R9 buffer drains to 0", {11'd0, status[12:8]}, 16'd0);
    chk("R9 overrun sticky", {15'd0, status[4]}, 16'd1);
    sread();
    swrite(16'h0000);
    chk("R9 overrun handshake clear", {15'd0, status[4]}, 16'd0);

    // R10: arrival and pop together on a full buffer
    do_reset();
    tsel = 2'd3;
    for (int j = 0; j < 16; j++) push(8'(8'h40 + j), 1'b0, 1'b0);
    push_pop(8'h55);
    chk("R10 count stays 16", {11'd0, status[12:8]}, 16'd16);
    chk("R10 no overrun", {15'd0, status[4]}, 16'd0);
    chk("R10 head advanced", {8'd0, rdata}, 16'h0041);
    for (int j = 0; j < 15; j++) pop1();
    chk("R10 new character stored last", {8'd0, rdata}, 16'h0055);

    // R7, R8: idle timeout (150 ticks, one tick per cycle)
    do_reset();
    tsel = 2'd1;
    tick = 1'b1;
    idle(200);
    chk("R7 no timeout when empty", {15'd0, status[0]}, 16'd0);
    push(8'h11, 1'b0, 1'b0);
    idle(100);
    push(8'h22, 1'b0, 1'b0);
    idle(100);
    chk("R7 arrival restarts timer", {15'd0, status[0]}, 16'd0);
    idle(60);
    chk("R7 timeout sets idle flag", {15'd0, status[0]}, 16'd1);
    tick = 1'b0;
    pop1();
    chk("R8 pop does not clear idle flag", {15'd0, status[0]}, 16'd1);
    sread();
    swrite(16'h0000);
    chk("R8 handshake clears idle flag", {15'd0, status[0]}, 16'd0);
    do_reset();
    tsel = 2'd1;
    for (int j = 0; j < 4; j++) push(8'(j), 1'b0, 1'b0);
    tick = 1'b1;
    idle(200);
    tick = 1'b0;
    chk("R7 no timeout at/above level", {15'd0, status[0]}, 16'd0);

    // R11: standby clears flags, keeps contents
    do_reset();
    tsel = 2'd0;
    push(8'h9A, 1'b1, 1'b1);
    idle(1);
    chk("R11 flags before standby", {11'd0, status[4:0]}, 16'h000E);
    @(negedge clk);
    standby = 1'b1;
    idle(2);
    chk("R11 flags zero in standby", {11'd0, status[4:0]}, 16'd0);
    chk("R11 count kept in standby", {11'd0, status[12:8]}, 16'd1);
    standby = 1'b0;
    idle(2);
    chk("R11 contents kept", {8'd0, rdata}, 16'h009A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule